// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers a vector of level-sensitive interrupt sources and drives two request outputs toward a processor: a normal request and a fast request. Every source lands in one shared raw level vector, and each output has its own enable mask. An output is high while at least one source is both active and enabled in that output's mask. Bit 0 of the raw vector can also be raised by software through a latch that the register bus sets and clears.

Software reaches the block over a simple word-addressed register bus with a select, a write flag, a word index and a data word. Read data is returned in the same cycle as the select. An enable mask never takes a plain write. A set word ORs the written ones into the mask, and a clear word removes them, so two agents can edit different bits without a read-modify-write. Raw source levels are captured in a register once per clock. Both request outputs are registered.

Top module: `dual_intc`

## Requirements
- R1: The normal request output `irq_o` rises one clock after (raw level AND normal mask) becomes nonzero, and falls one clock after it becomes zero.
- R2: The fast request output `fiq_o` follows (raw level AND fast mask) with the same one-clock registered delay, independently of the normal mask.
- R3: A write to word 2 ORs the data into the normal mask. A write to word 3 clears the mask bits that are one in the data. Reading word 2 returns the normal mask.
- R4: A write to word 10 ORs the data into the fast mask. A write to word 11 clears the bits that are one in the data. Reading word 10 returns the fast mask. Edits to one mask leave the other unchanged.
- R5: Reading word 0 returns raw level AND normal mask. Reading word 8 returns raw level AND fast mask.
- R6: Reading word 1 or word 9 returns the raw level vector. Each raw bit takes the level of its source input one clock after the input changes.
- R7: A write to word 4 with data bit 0 set raises the software latch. A write to word 5 with data bit 0 set lowers it. Either write with data bit 0 clear has no effect. Reading word 4 returns raw level bit 0 in bit 0 and zeros above.
- R8: Raw level bit 0 is the OR of source input 0 and the software latch.
- R9: Reads of words 3, 5 and 11 and of every unmapped word return zero. Writes to words 0, 1, 8, 9 and to unmapped words change no state.
- R10: After reset both masks, the software latch and the raw vector are zero, and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | N_SRC | Level-sensitive interrupt sources |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word index |
| bus_wdata_i | input | N_SRC | Write data |
| bus_rdata_o | output | N_SRC | Read data, valid in the cycle of a read select |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The sources are driven with a sparse alternating pattern and then with all zeros. This separates the raw view from the masked views and shows whether an output falls when its sources fall or only when its mask changes. The masks are edited by overlapping set and clear writes on disjoint bit groups, and each edit is followed by a read of the other mask. A wrong OR, a wrong clear or a crossed channel shows up as a wrong read value. The software latch is exercised with bit 0 both set and clear in the data, alone and together with hardware source 0, which separates the OR on bit 0 from a plain overwrite. Invalid words are both read and written with all ones, so that a decode leak shows up in a mask or in the raw view.

// File: rtl/dintc_pkg.sv
package dintc_pkg;
  // Word indices on the register bus
  localparam int unsigned W_IRQ_STAT = 0;
  localparam int unsigned W_RAW_A    = 1;
  localparam int unsigned W_IRQ_EN   = 2;
  localparam int unsigned W_IRQ_OFF  = 3;
  localparam int unsigned W_SOFT_ON  = 4;
  localparam int unsigned W_SOFT_OFF = 5;
  localparam int unsigned W_FIQ_STAT = 8;
  localparam int unsigned W_RAW_B    = 9;
  localparam int unsigned W_FIQ_EN   = 10;
  localparam int unsigned W_FIQ_OFF  = 11;

  localparam int unsigned N_CHAN = 2;
  localparam int unsigned CH_IRQ = 0;
  localparam int unsigned CH_FIQ = 1;

  typedef struct packed {
    logic [N_CHAN-1:0] en_set;
    logic [N_CHAN-1:0] en_clr;
    logic              soft_on;
    logic              soft_off;
  } dintc_wr_t;
endpackage

// File: rtl/dintc_rst_sync.sv
module dintc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dintc_src_latch.sv
module dintc_src_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         soft_on_i,
  input  logic         soft_off_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] hw_q, hw_d;
  logic         soft_q, soft_d, soft_ce;

  always_comb begin
    hw_d    = src_i;
    soft_ce = soft_on_i | soft_off_i;
    soft_d  = soft_on_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q   <= '0;
      soft_q <= 1'b0;
    end else begin
      hw_q <= hw_d;
      if (soft_ce) soft_q <= soft_d;
    end
  end

  // software source is merged into bit 0 only
  assign raw_o = hw_q | W'(soft_q);

  p_raw_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_o | W'(1)) == ($past(src_i) | W'(1)));
  p_soft_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_on_i |=> raw_o[0]);
  p_soft_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_off_i && !soft_on_i) |=> (raw_o[0] == $past(src_i[0])));
endmodule

// File: rtl/dintc_mask_reg.sv
module dintc_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q, mask_d;
  logic         mask_ce;

  always_comb begin
    mask_ce = set_i | clr_i;
    mask_d  = set_i ? (mask_q | data_i) : (mask_q & ~data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // shared by both channels: covers R3 and R4
  p_set_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ((mask_o & $past(data_i)) == $past(data_i)));
  p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> ((mask_o & $past(data_i)) == '0));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(mask_o));
endmodule

// File: rtl/dintc_out_stage.sv
module dintc_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] en_i,
  output logic         req_o
);
  logic req_q, req_d, req_ce;

  always_comb begin
    req_d  = |(raw_i & en_i);
    req_ce = req_d ^ req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (req_ce) req_q <= req_d;
  end

  assign req_o = req_q;

  // shared by both channels: covers R1 and R2
  p_out_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_i & en_i)) |=> req_o);
  p_out_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(raw_i & en_i)) |=> !req_o);
endmodule

// File: rtl/dual_intc.sv
module dual_intc #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N_SRC-1:0]  bus_wdata_i,
  output logic [N_SRC-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  import dintc_pkg::*;

  logic                          rst_n_s;
  logic                          wr_hit, rd_hit;
  dintc_wr_t                     wr_s;
  logic [N_SRC-1:0]              raw;
  logic [N_CHAN-1:0][N_SRC-1:0]  en;
  logic [N_CHAN-1:0]             req;
  logic [N_SRC-1:0]              rdata;

  dintc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  // write decode
  always_comb begin
    wr_hit = bus_sel_i & bus_wr_i;
    rd_hit = bus_sel_i & ~bus_wr_i;
    wr_s   = '0;
    if (wr_hit) begin
      case (bus_addr_i)
        ADDR_W'(W_IRQ_EN):   wr_s.en_set[CH_IRQ] = 1'b1;
        ADDR_W'(W_IRQ_OFF):  wr_s.en_clr[CH_IRQ] = 1'b1;
        ADDR_W'(W_FIQ_EN):   wr_s.en_set[CH_FIQ] = 1'b1;
        ADDR_W'(W_FIQ_OFF):  wr_s.en_clr[CH_FIQ] = 1'b1;
        ADDR_W'(W_SOFT_ON):  wr_s.soft_on  = bus_wdata_i[0];
        ADDR_W'(W_SOFT_OFF): wr_s.soft_off = bus_wdata_i[0];
        default: ;
      endcase
    end
  end

  dintc_src_latch #(.W(N_SRC)) u_src (
    .clk(clk), .rst_n(rst_n_s), .src_i(src_i),
    .soft_on_i(wr_s.soft_on), .soft_off_i(wr_s.soft_off), .raw_o(raw)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    dintc_mask_reg #(.W(N_SRC)) u_mask (
      .clk(clk), .rst_n(rst_n_s),
      .set_i(wr_s.en_set[c]), .clr_i(wr_s.en_clr[c]),
      .data_i(bus_wdata_i), .mask_o(en[c])
    );
    dintc_out_stage #(.W(N_SRC)) u_out (
      .clk(clk), .rst_n(rst_n_s),
      .raw_i(raw), .en_i(en[c]), .req_o(req[c])
    );
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (bus_addr_i)
        ADDR_W'(W_IRQ_STAT): rdata = raw & en[CH_IRQ];
        ADDR_W'(W_RAW_A):    rdata = raw;
        ADDR_W'(W_IRQ_EN):   rdata = en[CH_IRQ];
        ADDR_W'(W_SOFT_ON):  rdata = N_SRC'(raw[0]);
        ADDR_W'(W_FIQ_STAT): rdata = raw & en[CH_FIQ];
        ADDR_W'(W_RAW_B):    rdata = raw;
        ADDR_W'(W_FIQ_EN):   rdata = en[CH_FIQ];
        default:             rdata = '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata;
  assign irq_o       = req[CH_IRQ];
  assign fiq_o       = req[CH_FIQ];

  p_bad_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_hit && (bus_addr_i == ADDR_W'(W_IRQ_OFF) || bus_addr_i == ADDR_W'(W_SOFT_OFF) ||
                bus_addr_i == ADDR_W'(W_FIQ_OFF))) |-> (bus_rdata_o == '0));
  p_bad_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_hit && (bus_addr_i == ADDR_W'(W_RAW_A) || bus_addr_i == ADDR_W'(W_FIQ_STAT)))
      |=> ($stable(en[CH_IRQ]) && $stable(en[CH_FIQ])));
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n_s |-> (!irq_o && !fiq_o));
endmodule

// File: tb/dual_intc_tb_top.sv
module dual_intc_tb_top;
  localparam int unsigned N = 32;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src;
  logic          sel, wr;
  logic [AW-1:0] addr;
  logic [N-1:0]  wdata, rdata;
  logic          irq, fiq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dual_intc #(.N_SRC(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input int unsigned a, input logic [N-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input int unsigned a, output logic [N-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = AW'(a);
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    check("R10 irq low", N'(irq), '0);
    check("R10 fiq low", N'(fiq), '0);
    bus_read(2, v);  check("R10 normal mask", v, '0);
    bus_read(10, v); check("R10 fast mask", v, '0);
    bus_read(1, v);  check("R10 raw", v, '0);
  endtask

  task automatic t_raw();
    logic [N-1:0] v;
    @(negedge clk); src = 32'hA5A5_0F0E;
    settle();
    bus_read(1, v); check("R6 raw word1", v, 32'hA5A5_0F0E);
    bus_read(9, v); check("R6 raw word9", v, 32'hA5A5_0F0E);
    check("R1 no mask no irq", N'(irq), '0);
  endtask

  task automatic t_irq_mask();
    logic [N-1:0] v;
    bus_write(2, 32'h0000_0F00); settle();
    bus_read(2, v); check("R3 set", v, 32'h0000_0F00);
    bus_read(0, v); check("R5 normal status", v, 32'h0000_0F00);
    check("R1 irq high", N'(irq), 1);
    check("R2 fiq stays low", N'(fiq), 0);
    bus_write(2, 32'h0000_0001);
    bus_read(2, v); check("R3 set ORs", v, 32'h0000_0F01);
    bus_write(3, 32'h0000_0300);
    bus_read(2, v); check("R3 clear", v, 32'h0000_0C01);
    bus_read(10, v); check("R4 fast mask untouched", v, '0);
  endtask

  task automatic t_fiq_mask();
    logic [N-1:0] v;
    bus_write(10, 32'h8000_0000); settle();
    check("R2 fiq high", N'(fiq), 1);
    bus_read(8, v); check("R5 fast status", v, 32'h8000_0000);
    bus_read(2, v); check("R4 normal mask untouched", v, 32'h0000_0C01);
    bus_write(11, 32'h8000_0000); settle();
    bus_read(10, v); check("R4 clear", v, '0);
    check("R2 fiq low after clear", N'(fiq), 0);
  endtask

  task automatic t_src_drop();
    logic [N-1:0] v;
    @(negedge clk); src = '0;
    settle();
    check("R1 irq falls with sources", N'(irq), 0);
    bus_read(0, v); check("R5 status zero", v, '0);
  endtask

  task automatic t_soft();
    logic [N-1:0] v;
    bus_write(4, 32'h0000_0002); settle();
    bus_read(1, v); check("R7 bit0 clear ignored", v, '0);
    check("R7 no irq", N'(irq), 0);
    bus_write(4, 32'h0000_0001); settle();
    bus_read(1, v); check("R7 soft raised", v, 32'h1);
    bus_read(4, v); check("R7 word4 read", v, 32'h1);
    check("R1 irq from soft", N'(irq), 1);
    bus_write(5, 32'hFFFF_FFFE); settle();
    bus_read(1, v); check("R7 clear bit0 zero ignored", v, 32'h1);
    bus_write(5, 32'h0000_0001); settle();
    bus_read(4, v); check("R7 soft lowered", v, '0);
    check("R1 irq falls", N'(irq), 0);
  endtask

  task automatic t_or_bit0();
    logic [N-1:0] v;
    bus_write(4, 32'h1);
    @(negedge clk); src = 32'h1;
    bus_write(5, 32'h1); settle();
    bus_read(1, v); check("R8 hw keeps bit0", v, 32'h1);
    @(negedge clk); src = '0; settle();
    bus_read(1, v); check("R8 bit0 clears", v, '0);
  endtask

  task automatic t_invalid();
    logic [N-1:0] v;
    bus_write(10, 32'h0000_00F0);
    bus_read(3, v);  check("R9 read word3", v, '0);
    bus_read(5, v);  check("R9 read word5", v, '0);
    bus_read(11, v); check("R9 read word11", v, '0);
    bus_read(6, v);  check("R9 read word6", v, '0);
    bus_read(15, v); check("R9 read word15", v, '0);
    bus_write(0, '1); bus_write(1, '1); bus_write(8, '1);
    bus_write(9, '1); bus_write(13, '1); settle();
    bus_read(2, v);  check("R9 normal mask held", v, 32'h0000_0C01);
    bus_read(10, v); check("R9 fast mask held", v, 32'h0000_00F0);
    bus_read(1, v);  check("R9 raw held", v, '0);
  endtask

  initial begin
    rst_n = 1'b0; src = '0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_raw();
    t_irq_mask();
    t_fiq_mask();
    t_src_drop();
    t_soft();
    t_or_bit0();
    t_invalid();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule